// File: doc/BRIEF.md
# Dual Retriggerable Clocked One-Shot

This block provides two independent pulse-stretching channels that run from one system clock. Each channel watches a pair of trigger inputs of opposite sense: one active low, one active high. A qualifying edge on either input makes the channel drive a pulse whose length is a programmed number of clock cycles. Every channel also has a complementary output and an active-low clear. The clear forces the output low and holds the channel idle.

Each pulse begins with a short blind phase of fixed length. Triggers that arrive during the blind phase are dropped. After the blind phase comes a charge phase that runs out the rest of the width. A trigger accepted during the charge phase starts timing again from the blind phase. This stretches the pulse to a full width measured from the newest accepted trigger. All asynchronous inputs pass through two-stage synchronizers before any edge is detected. A channel that is not in use is parked by keeping its clear low.

Top module: `oneshot_pair`

## Requirements
- R1: After reset every `pulse` bit is 0 and every `pulse_n` bit is 1. `pulse_n` is always the inverse of `pulse`.
- R2: A channel fires in two cases only. The first is a 0-to-1 change of `trig_b` while `trig_a_n` is 0. The second is a 1-to-0 change of `trig_a_n` while `trig_b` is 1. The following produce no pulse: `trig_b` rising while `trig_a_n` is 1, `trig_a_n` falling while `trig_b` is 0, and a falling `trig_b` or a rising `trig_a_n`.
- R3: Suppose a qualifying input change is set up before clock edge k. Then `pulse` goes high after edge k+2. When the width W is greater than BLIND_CYC, `pulse` stays high for exactly W cycles.
- R4: Let an accepted trigger be evaluated at edge E. A qualifying trigger evaluated after the first BLIND_CYC cycles of the pulse restarts timing. `pulse` then stays high without a gap until W cycles after that trigger's own rise point.
- R5: A trigger evaluated within the first BLIND_CYC cycles of a pulse has no effect. The pulse ends as if that trigger had not occurred.
- R6: Suppose `clear_n` is driven low before edge k during a pulse. Then `pulse` is low after edge k+1, and the channel returns to idle.
- R7: While the synchronized clear is low, every trigger is ignored. Releasing clear while `trig_a_n` is 0 and `trig_b` is 1 does not start a pulse.
- R8: If the width is zero when a trigger arrives at an idle channel, no pulse is produced.
- R9: If the width W is nonzero and not greater than BLIND_CYC, the pulse lasts BLIND_CYC+1 cycles. The charge phase never shortens below one cycle.
- R10: The channels do not interact. Activity, widths or clear on one channel leave the other channel's output unchanged.
- R11: The width is captured when a trigger is accepted. Changing `width_cfg` during a pulse does not alter that pulse's length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_a_n | input | NCH | Active-low trigger per channel, fires on its falling edge |
| trig_b | input | NCH | Active-high trigger per channel, fires on its rising edge |
| clear_n | input | NCH | Active-low clear per channel |
| width_cfg | input | NCH*CNT_W | Pulse width per channel in clock cycles, channel c at bits c*CNT_W upward |
| pulse | output | NCH | Active-high pulse per channel |
| pulse_n | output | NCH | Inverse of `pulse` |

## Verification
The bench builds the block with two channels, an 8-bit width counter and a blind phase of 4 cycles. The small blind phase puts both retrigger boundaries within a few cycles of the first trigger: the last dropped trigger and the first accepted one. The same setting lets widths of 2, 4 and 5 test the charge-phase floor on either side of the blind length. Widths of 12 and 20 keep each pulse short, so extended, aborted and two-channel pulses all complete within a few hundred cycles.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_DISCH  = 2'd1,
    PH_CHARGE = 2'd2
  } phase_e;

  // Cycles spent in the charge phase for a given width; never below one.
  function automatic int unsigned charge_cycles(input int unsigned width,
                                                input int unsigned blind);
    if (width > blind) return width - blind;
    return 1;
  endfunction

endpackage

// File: rtl/os_sync.sv
module os_sync #(
  parameter int unsigned     W       = 1,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] stage1, stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      stage2 <= RST_VAL;
    end else begin
      stage1 <= d_in;
      stage2 <= stage1;
    end
  end

  assign d_out = stage2;
endmodule

// File: rtl/os_trig_qual.sv
module os_trig_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic a_lvl_n,
  input  logic b_lvl,
  output logic fire
);
  logic a_prev, b_prev;
  logic b_rise, a_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_prev <= 1'b1;
      b_prev <= 1'b0;
    end else begin
      a_prev <= a_lvl_n;
      b_prev <= b_lvl;
    end
  end

  assign b_rise = b_lvl & ~b_prev;
  assign a_fall = ~a_lvl_n & a_prev;
  assign fire   = (b_rise & ~a_lvl_n) | (a_fall & b_lvl);

  // R2: a firing always coincides with the gating level of both inputs
  a_r2_fire_levels: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (!a_lvl_n && b_lvl));
endmodule

// File: rtl/os_chan_timer.sv
module os_chan_timer
  import oneshot_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned BLIND_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_ok,
  input  logic             fire,
  input  logic [CNT_W-1:0] width,
  output logic             q
);
  localparam logic [CNT_W-1:0] BLIND_M1 = CNT_W'(BLIND_CYC - 1);

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] chg_m1;
  logic [CNT_W-1:0] chg_m1_next;

  // Named events for assertions
  logic start_ok, retrig_ok, blind_drop, disch_end, charge_end;

  assign chg_m1_next = CNT_W'(charge_cycles(32'(width), BLIND_CYC) - 1);
  assign start_ok    = clr_ok && (phase == PH_IDLE) && fire && (width != '0);
  assign retrig_ok   = clr_ok && (phase == PH_CHARGE) && fire;
  assign blind_drop  = clr_ok && (phase == PH_DISCH) && fire;
  assign disch_end   = clr_ok && (phase == PH_DISCH) && (cnt == '0);
  assign charge_end  = clr_ok && (phase == PH_CHARGE) && !fire && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      chg_m1 <= '0;
    end else if (!clr_ok) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (start_ok) begin
            phase  <= PH_DISCH;
            cnt    <= BLIND_M1;
            chg_m1 <= chg_m1_next;
          end
        end
        PH_DISCH: begin
          if (disch_end) begin
            phase <= PH_CHARGE;
            cnt   <= chg_m1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_CHARGE: begin
          if (retrig_ok) begin
            phase  <= PH_DISCH;
            cnt    <= BLIND_M1;
            chg_m1 <= chg_m1_next;
          end else if (charge_end) begin
            phase <= PH_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign q = (phase != PH_IDLE) && clr_ok;

  // R6: a low clear always leaves the channel idle on the next cycle
  a_r6_clear_idles: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_ok |=> (phase == PH_IDLE));
  // R3: an accepted start enters the blind phase with a full blind count
  a_r3_start_blind: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (phase == PH_DISCH) && (cnt == BLIND_M1));
  // R3: pulse stays active across the blind-to-charge change
  a_r3_phase_handoff: assert property (@(posedge clk) disable iff (!rst_n)
    disch_end |=> (phase == PH_CHARGE) && q);
  // R4: a charge-phase trigger reloads the blind count
  a_r4_retrig_reload: assert property (@(posedge clk) disable iff (!rst_n)
    retrig_ok |=> (phase == PH_DISCH) && (cnt == BLIND_M1));
  // R5: a trigger inside the blind phase does not disturb the countdown
  a_r5_blind_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (blind_drop && (cnt != '0)) |=> (phase == PH_DISCH) && (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/oneshot_pair.sv
module oneshot_pair #(
  parameter int unsigned NCH       = 2,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned BLIND_CYC = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       trig_a_n,
  input  logic [NCH-1:0]       trig_b,
  input  logic [NCH-1:0]       clear_n,
  input  logic [NCH*CNT_W-1:0] width_cfg,
  output logic [NCH-1:0]       pulse,
  output logic [NCH-1:0]       pulse_n
);
  localparam logic [NCH-1:0] ALL_ONE  = {NCH{1'b1}};
  localparam logic [NCH-1:0] ALL_ZERO = {NCH{1'b0}};

  logic [NCH-1:0] a_s, b_s, clr_s;

  os_sync #(.W(NCH), .RST_VAL(ALL_ONE))  u_sync_a   (.clk(clk), .rst_n(rst_n), .d_in(trig_a_n), .d_out(a_s));
  os_sync #(.W(NCH), .RST_VAL(ALL_ZERO)) u_sync_b   (.clk(clk), .rst_n(rst_n), .d_in(trig_b),   .d_out(b_s));
  os_sync #(.W(NCH), .RST_VAL(ALL_ZERO)) u_sync_clr (.clk(clk), .rst_n(rst_n), .d_in(clear_n),  .d_out(clr_s));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic fire;

    os_trig_qual u_qual (
      .clk     (clk),
      .rst_n   (rst_n),
      .a_lvl_n (a_s[c]),
      .b_lvl   (b_s[c]),
      .fire    (fire)
    );

    os_chan_timer #(.CNT_W(CNT_W), .BLIND_CYC(BLIND_CYC)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_ok (clr_s[c]),
      .fire   (fire),
      .width  (width_cfg[c*CNT_W +: CNT_W]),
      .q      (pulse[c])
    );
  end

  assign pulse_n = ~pulse;
endmodule

// File: tb/test_oneshot_pair.sv
`timescale 1ns/1ps
module test_oneshot_pair;
  localparam int CW = 8;
  localparam int D  = 4;

  typedef struct {
    int    start;
    int    len;
    string tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    a_n = 2'b11;
  logic [1:0]    b = 2'b00;
  logic [1:0]    clr_n = 2'b11;
  logic [2*CW-1:0] wcfg = '0;
  logic [1:0]    pulse, pulse_n;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int comp_err = 0;
  bit done = 0;
  item_t exp0[$];
  item_t exp1[$];
  logic [1:0] q_prev = 2'b00;
  int start_c[2];

  oneshot_pair #(.NCH(2), .CNT_W(CW), .BLIND_CYC(D)) i_oneshot_pair (
    .clk(clk), .rst_n(rst_n), .trig_a_n(a_n), .trig_b(b), .clear_n(clr_n),
    .width_cfg(wcfg), .pulse(pulse), .pulse_n(pulse_n)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int exp_len(input int w);
    if (w == 0) return 0;
    return (w < D + 1) ? D + 1 : w;
  endfunction

  task automatic push(input int c, input int st, input int len, input string tag);
    item_t it;
    it.start = st; it.len = len; it.tag = tag;
    if (c == 0) exp0.push_back(it); else exp1.push_back(it);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_w(input int c, input int v);
    wcfg[c*CW +: CW] = CW'(v);
  endtask

  task automatic b_pulse(input int c, output int n);
    n = cyc;
    b[c] = 1'b1;
    tick(1);
    b[c] = 1'b0;
  endtask

  // Monitor: measures each pulse and compares it against the scoreboard
  task automatic got_pulse(input int c, input int st, input int len);
    item_t it;
    if ((c == 0 && exp0.size() == 0) || (c == 1 && exp1.size() == 0)) begin
      chk(1'b0, $sformatf("R2 unexpected pulse ch%0d len", c), len, 0);
      return;
    end
    it = (c == 0) ? exp0.pop_front() : exp1.pop_front();
    chk(st == it.start, {it.tag, " start"}, st, it.start);
    chk(len == it.len, {it.tag, " length"}, len, it.len);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < 2; c++) begin
        if (pulse_n[c] !== ~pulse[c]) comp_err++;
        if (pulse[c] && !q_prev[c]) start_c[c] = cyc;
        if (!pulse[c] && q_prev[c]) got_pulse(c, start_c[c], cyc - start_c[c]);
      end
      q_prev = pulse;
    end
  end

  task automatic retrig(input int c, input int gap, input int w, input string tag);
    int n, n2;
    b_pulse(c, n);
    push(c, n + 3, (gap >= D + 1) ? gap + w : w, tag);
    tick(gap - 1);
    b_pulse(c, n2);
    tick(gap + w + 8);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    set_w(0, 20); set_w(1, 12);
    tick(3);
    // R1 reset state
    chk(pulse == 2'b00, "R1 reset pulse", pulse, 0);
    chk(pulse_n == 2'b11, "R1 reset pulse_n", pulse_n, 3);
    rst_n = 1'b1;
    tick(6);

    // R2: B rises with A high -> nothing
    b_pulse(0, n); tick(30);
    chk(pulse[0] == 1'b0, "R2 b rise with a high", pulse[0], 0);
    // R2: A falls with B low -> nothing
    a_n[0] = 1'b0; tick(8);
    chk(pulse[0] == 1'b0, "R2 a fall with b low", pulse[0], 0);
    // R3: B rises with A low -> pulse of width
    b_pulse(0, n); push(0, n + 3, exp_len(20), "R3 b trigger");
    tick(40);
    // R2: A falls while B high
    a_n[0] = 1'b1; tick(4);
    b[0] = 1'b1; tick(6);
    n = cyc; a_n[0] = 1'b0; push(0, n + 3, 20, "R2 a trigger");
    tick(40);
    b[0] = 1'b0; tick(6);
    a_n[0] = 1'b1; tick(20);
    chk(pulse[0] == 1'b0, "R2 b fall / a rise", pulse[0], 0);
    a_n[0] = 1'b0; tick(6);

    // R4 / R5 retrigger spacing
    retrig(0, 10, 20, "R4 charge retrigger");
    retrig(0, 5, 20, "R4 first accepted gap");
    retrig(0, 2, 20, "R5 blind retrigger");
    retrig(0, 4, 20, "R5 last ignored gap");

    // R6 clear aborts a pulse
    b_pulse(0, n); push(0, n + 3, 7, "R6 clear abort");
    tick(7);
    clr_n[0] = 1'b0; tick(10);
    chk(pulse[0] == 1'b0, "R6 pulse low during clear", pulse[0], 0);
    // R7 triggers ignored while cleared
    b_pulse(0, n); tick(6);
    a_n[0] = 1'b1; b[0] = 1'b1; tick(4);
    a_n[0] = 1'b0; tick(10);
    chk(pulse[0] == 1'b0, "R7 trigger under clear", pulse[0], 0);
    clr_n[0] = 1'b1; tick(30);
    chk(pulse[0] == 1'b0, "R7 release with a low b high", pulse[0], 0);
    b[0] = 1'b0; tick(6);

    // R8 width zero
    set_w(0, 0); b_pulse(0, n); tick(30);
    chk(pulse[0] == 1'b0, "R8 zero width", pulse[0], 0);
    // R9 short widths
    set_w(0, 2); b_pulse(0, n); push(0, n + 3, D + 1, "R9 width 2"); tick(20);
    set_w(0, 4); b_pulse(0, n); push(0, n + 3, D + 1, "R9 width equal blind"); tick(20);
    set_w(0, 5); b_pulse(0, n); push(0, n + 3, 5, "R9 width blind plus one"); tick(20);
    // R11 width captured at trigger
    set_w(0, 20); b_pulse(0, n); push(0, n + 3, 20, "R11 width change mid pulse");
    tick(2); set_w(0, 40); tick(60); set_w(0, 20);

    // R10 independent channels
    a_n[1] = 1'b0; tick(6);
    n = cyc; b = 2'b11; tick(1); b = 2'b00;
    push(0, n + 3, 20, "R10 ch0 concurrent");
    push(1, n + 3, 12, "R10 ch1 concurrent");
    tick(40);
    clr_n[0] = 1'b0; tick(4);
    b_pulse(1, n); push(1, n + 3, 12, "R10 ch1 with ch0 parked");
    tick(6);
    chk(pulse == 2'b10, "R10 ch0 parked while ch1 runs", pulse, 2);
    tick(20);
    clr_n[0] = 1'b1; tick(6);

    chk(exp0.size() == 0, "R3 ch0 pulses all seen", exp0.size(), 0);
    chk(exp1.size() == 0, "R10 ch1 pulses all seen", exp1.size(), 0);
    chk(comp_err == 0, "R1 complement mismatches", comp_err, 0);
    done = 1;
    summary();
    $finish;
  end
endmodule